// File: doc/BRIEF.md
# Nibble Data Memory with Overlaid Registers

This block is the data store of a small 4-bit processor. It is one flat array of 256 nibbles addressed by an 8-bit address. The lowest 16 addresses form the processor's register page, so each register is simply a memory cell. Two cells in that page are given over to general-purpose I/O. One returns the state of four external input pins after a two-flop synchroniser. The other holds a nibble that drives four output pins.

The processor uses one port. Reads on it are combinational and writes are taken on the rising clock edge. A second, read-only port feeds a 16×8 LED matrix. That port shows a window of two neighbouring 16-nibble banks. A row-select bit picks one of the two banks and a 4-bit column picks the nibble inside it. The first bank of the window is chosen at run time through a load strobe and defaults to bank 0 after reset, so the register page and the page after it are on view.

Top module: `nibble_dmem`

## Requirements
- R1: A CPU write (cpu_we high) stores cpu_wdata at cpu_addr on the rising edge. Any later CPU read of that address in 0x10..0xFF returns the stored nibble combinationally.
- R2: A CPU write to the input cell at address 0x0B has no effect. A read of 0x0B still returns the synchronised pins, and gpio_out is unchanged.
- R3: A read of address 0x0B returns gpio_in as sampled by two flops. A pin change is not yet visible after one rising edge and is visible after the second.
- R4: A CPU write to address 0x0A loads gpio_out on that edge. gpio_out holds its value in every cycle without such a write. A read of 0x0A returns the current gpio_out.
- R5: Page-0 addresses other than 0x0A and 0x0B (the registers R0..R9 at 0x00..0x09 and 0x0C..0x0F) behave as ordinary storage.
- R6: After reset, gpio_out is 0 and the display window starts at bank 0.
- R7: disp_data returns the nibble at address {window_bank + disp_row, disp_col}. For addresses 0x0A and 0x0B it shows the live output and synchronised input values.
- R8: A high disp_sel_we loads disp_sel_bank as the window bank on the rising edge, and the bank holds while the strobe is low. Bank 15 with disp_row = 1 wraps round to bank 0.
- R9: The display port is independent of the CPU port. A CPU write to another address does not disturb disp_data, and a CPU cycle with cpu_we low changes no stored nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| arst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | CPU nibble address |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 4 | CPU write data |
| cpu_rdata | output | 4 | CPU read data (combinational) |
| gpio_in | input | 4 | External input pins (asynchronous) |
| gpio_out | output | 4 | External output pins |
| disp_sel_we | input | 1 | Load strobe for the window bank |
| disp_sel_bank | input | 4 | New first bank of the display window |
| disp_row | input | 1 | Selects the first (0) or second (1) bank of the window |
| disp_col | input | 4 | Nibble index within the selected bank |
| disp_data | output | 4 | Nibble shown at the addressed display position |

## Verification
A table of writes spread over page 0, the page above it, the middle of the array and its top address is read back. This separates general storage from the register cells and catches address bits that are dropped or swapped. The input cell is tried with pin changes read one and two edges later, and with a conflicting CPU write, which separates the synchroniser latency from any write leakage. The window is moved to banks 0, 3 and 15, with and without the load strobe. This tells correct row addition and wrap-round apart from a window that is fixed or loaded at the wrong time. It also checks that CPU traffic leaves the display port undisturbed.

// File: rtl/nmem_pkg.sv
`timescale 1ns/1ps
package nmem_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 4;
  localparam int COL_W  = 4;

  localparam logic [ADDR_W-1:0] GPIO_OUT_ADDR = 8'h0A;
  localparam logic [ADDR_W-1:0] GPIO_IN_ADDR  = 8'h0B;

  typedef enum logic [1:0] {
    CELL_RAM,
    CELL_IN,
    CELL_OUT
  } cell_e;

  function automatic cell_e classify(input logic [ADDR_W-1:0] a);
    if (a == GPIO_IN_ADDR)       return CELL_IN;
    else if (a == GPIO_OUT_ADDR) return CELL_OUT;
    else                         return CELL_RAM;
  endfunction
endpackage

// File: rtl/nmem_rst_sync.sv
`timescale 1ns/1ps
module nmem_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/nmem_sync.sv
`timescale 1ns/1ps
module nmem_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

  AST_SYNC_FIRST:  assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> meta_q == $past(d)); // R3
  AST_SYNC_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sync_q == $past(meta_q)); // R3
endmodule

// File: rtl/nmem_array.sv
`timescale 1ns/1ps
module nmem_array #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/nmem_window.sv
`timescale 1ns/1ps
module nmem_window #(
  parameter int AW    = 8,
  parameter int COL_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_we,
  input  logic [AW-COL_W-1:0] sel_bank,
  input  logic                row,
  input  logic [COL_W-1:0]    col,
  output logic [AW-1:0]       disp_addr
);
  localparam int BANK_W = AW - COL_W;

  logic [BANK_W-1:0] bank_q, bank_d, shown_bank;

  always_comb begin
    bank_d = bank_q;
    if (sel_we) bank_d = sel_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign shown_bank = bank_q + {{(BANK_W-1){1'b0}}, row};
  assign disp_addr  = {shown_bank, col};

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> bank_q == $past(sel_bank)); // R8
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(bank_q)); // R8
endmodule

// File: rtl/nibble_dmem.sv
`timescale 1ns/1ps
module nibble_dmem
  import nmem_pkg::*;
#(
  parameter int AW = nmem_pkg::ADDR_W,
  parameter int DW = nmem_pkg::DATA_W,
  parameter int CW = nmem_pkg::COL_W
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [AW-1:0]    cpu_addr,
  input  logic             cpu_we,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  input  logic [DW-1:0]    gpio_in,
  output logic [DW-1:0]    gpio_out,
  input  logic             disp_sel_we,
  input  logic [AW-CW-1:0] disp_sel_bank,
  input  logic             disp_row,
  input  logic [CW-1:0]    disp_col,
  output logic [DW-1:0]    disp_data
);
  logic          rst_n;
  logic [DW-1:0] in_sync;
  logic [DW-1:0] out_q, out_d;
  logic [AW-1:0] disp_addr;
  logic [DW-1:0] ram_cpu, ram_disp;
  cell_e         cpu_cell, disp_cell;
  logic          ram_we, out_we;

  nmem_rst_sync i_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  nmem_sync #(.W(DW)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (gpio_in),
    .q     (in_sync)
  );

  nmem_window #(.AW(AW), .COL_W(CW)) i_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (disp_sel_we),
    .sel_bank  (disp_sel_bank),
    .row       (disp_row),
    .col       (disp_col),
    .disp_addr (disp_addr)
  );

  assign cpu_cell  = classify(cpu_addr);
  assign disp_cell = classify(disp_addr);
  assign ram_we    = cpu_we && (cpu_cell == CELL_RAM);
  assign out_we    = cpu_we && (cpu_cell == CELL_OUT);

  nmem_array #(.AW(AW), .DW(DW)) i_array (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (cpu_addr),
    .wdata   (cpu_wdata),
    .raddr_a (cpu_addr),
    .rdata_a (ram_cpu),
    .raddr_b (disp_addr),
    .rdata_b (ram_disp)
  );

  always_comb begin
    out_d = out_q;
    if (out_we) out_d = cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign gpio_out = out_q;

  always_comb begin
    unique case (cpu_cell)
      CELL_IN:  cpu_rdata = in_sync;
      CELL_OUT: cpu_rdata = out_q;
      default:  cpu_rdata = ram_cpu;
    endcase
  end

  always_comb begin
    unique case (disp_cell)
      CELL_IN:  disp_data = in_sync;
      CELL_OUT: disp_data = out_q;
      default:  disp_data = ram_disp;
    endcase
  end

  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == GPIO_OUT_ADDR) |=> gpio_out == $past(cpu_wdata)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_addr == GPIO_OUT_ADDR) |=> $stable(gpio_out)); // R4
  AST_IN_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == GPIO_IN_ADDR) |=> $stable(gpio_out)); // R2
endmodule

// File: tb/test_nibble_dmem.sv
`timescale 1ns/1ps
module test_nibble_dmem;
  logic       clk;
  logic       arst_n;
  logic [7:0] cpu_addr;
  logic       cpu_we;
  logic [3:0] cpu_wdata;
  logic [3:0] cpu_rdata;
  logic [3:0] gpio_in;
  logic [3:0] gpio_out;
  logic       disp_sel_we;
  logic [3:0] disp_sel_bank;
  logic       disp_row;
  logic [3:0] disp_col;
  logic [3:0] disp_data;

  int nchk  = 0;
  int nfail = 0;

  // each entry: {address, data}; addresses are unique
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    12'h003, 12'h09C, 12'h0C5, 12'h0FA, 12'h101,
    12'h3FE, 12'h806, 12'hFF9, 12'hA5F, 12'h1A2
  };

  nibble_dmem i_nibble_dmem (
    .clk           (clk),
    .arst_n        (arst_n),
    .cpu_addr      (cpu_addr),
    .cpu_we        (cpu_we),
    .cpu_wdata     (cpu_wdata),
    .cpu_rdata     (cpu_rdata),
    .gpio_in       (gpio_in),
    .gpio_out      (gpio_out),
    .disp_sel_we   (disp_sel_we),
    .disp_sel_bank (disp_sel_bank),
    .disp_row      (disp_row),
    .disp_col      (disp_col),
    .disp_data     (disp_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] a, output logic [3:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic disp_read(input logic r, input logic [3:0] c, output logic [3:0] d);
    @(negedge clk);
    disp_row = r; disp_col = c;
    #1 d = disp_data;
  endtask

  task automatic sel_bank(input logic [3:0] b);
    @(negedge clk);
    disp_sel_bank = b; disp_sel_we = 1'b1;
    @(negedge clk);
    disp_sel_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [3:0] v;
    arst_n = 1'b0; cpu_addr = '0; cpu_we = 1'b0; cpu_wdata = '0;
    gpio_in = 4'h0; disp_sel_we = 1'b0; disp_sel_bank = '0;
    disp_row = 1'b0; disp_col = '0;
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: reset state
    #1 chk("R6 gpio_out after reset", gpio_out, 4'h0);

    // R1 / R5: table of writes, then read back
    for (int i = 0; i < NV; i++) cpu_write(VEC[i][11:4], VEC[i][3:0]);
    for (int i = 0; i < NV; i++) begin
      cpu_read(VEC[i][11:4], v);
      if (VEC[i][11:8] == 4'h0) chk("R5 page-0 storage", v, VEC[i][3:0]);
      else                      chk("R1 storage read-back", v, VEC[i][3:0]);
    end

    // R6 / R7: default window is banks 0 and 1
    disp_read(1'b0, 4'h9, v); chk("R6 default window bank 0", v, 4'hC);
    disp_read(1'b1, 4'h0, v); chk("R7 window row 1 col 0", v, 4'h1);
    disp_read(1'b1, 4'hA, v); chk("R7 window row 1 col A", v, 4'h2);

    // R4: output cell
    cpu_write(8'h0A, 4'h6);
    #1 chk("R4 gpio_out loaded", gpio_out, 4'h6);
    cpu_read(8'h0A, v); chk("R4 read of output cell", v, 4'h6);
    cpu_read(8'h10, v);
    #1 chk("R4 gpio_out held", gpio_out, 4'h6);
    disp_read(1'b0, 4'hA, v); chk("R7 display shows output cell", v, 4'h6);

    // R3: input synchroniser latency
    @(negedge clk);
    cpu_addr = 8'h0B; gpio_in = 4'h9;
    @(negedge clk); #1 chk("R3 input after one edge", cpu_rdata, 4'h0);
    @(negedge clk); #1 chk("R3 input after two edges", cpu_rdata, 4'h9);
    disp_read(1'b0, 4'hB, v); chk("R7 display shows input cell", v, 4'h9);

    // R2: write to input cell ignored
    cpu_write(8'h0B, 4'h3);
    cpu_read(8'h0B, v); chk("R2 input cell after write", v, 4'h9);
    #1 chk("R2 gpio_out after input-cell write", gpio_out, 4'h6);

    // R8: window selection and wrap
    sel_bank(4'hF);
    disp_read(1'b0, 4'hF, v); chk("R8 bank 15 row 0", v, 4'h9);
    disp_read(1'b1, 4'hC, v); chk("R8 bank 15 row 1 wraps to 0", v, 4'h5);
    sel_bank(4'h3);
    disp_read(1'b0, 4'hF, v); chk("R8 bank 3 row 0", v, 4'hE);
    @(negedge clk);
    disp_sel_bank = 4'h7;
    @(negedge clk);
    disp_row = 1'b0; disp_col = 4'hF;
    #1 chk("R8 bank held without strobe", disp_data, 4'hE);

    // R9: display independent of CPU traffic
    sel_bank(4'hA);
    @(negedge clk);
    disp_row = 1'b0; disp_col = 4'h5;
    cpu_addr = 8'hA6; cpu_wdata = 4'h3; cpu_we = 1'b1;
    #1 chk("R9 display during CPU write", disp_data, 4'hF);
    @(negedge clk);
    cpu_we = 1'b0;
    #1 chk("R9 display after CPU write", disp_data, 4'hF);
    @(negedge clk);
    cpu_addr = 8'h80; cpu_wdata = 4'h0; cpu_we = 1'b0;
    @(negedge clk);
    cpu_read(8'h80, v); chk("R9 no store without cpu_we", v, 4'h6);
    cpu_read(8'hA6, v); chk("R1 store during display read", v, 4'h3);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule